// File: doc/BRIEF.md
# Chained Block Cipher Mode Engine

This block applies ECB or CBC chaining around an external 128-bit block cipher. The cipher core is not part of the block. It sits on a loop of two AXI4-Stream links: a request stream going out to the cipher and a result stream coming back. Plaintext or ciphertext words arrive on an input stream, and the chained words leave on an output stream.

Work is organised in groups. A one-cycle `grp_start` pulse, given while the engine is idle, captures four things: the group length in 128-bit words, the chaining mode, the direction, and a 128-bit initial vector assembled from four 32-bit words. The engine then handles the whole group one word at a time. For each word it takes the word in, sends the formed cipher input, waits for the result, and delivers the output word. When the last output word has been handed over, it raises `grp_done` for one cycle.

Top module: `cbc_chain_engine`

## Requirements
- R1: While reset is held, and after it until a group is started, `in_tready`, `cph_req_tvalid`, `cph_res_tready`, `out_tvalid` and `grp_done` are all 0.
- R2: A `grp_start` pulse is accepted only while the engine is idle. On acceptance, `cfg_chain`, `cfg_encrypt`, `grp_len` and the IV words are captured. A pulse given while a group is running is ignored, and configuration inputs that change after acceptance do not affect the running group.
- R3: With `cfg_chain`=0 (ECB), each input word is sent to the cipher unchanged, and each cipher result is delivered unchanged as the output word.
- R4: With `cfg_chain`=1 and `cfg_encrypt`=1 (CBC encrypt), the cipher input is the word XOR the chain value. The result is the output word, and it becomes the new chain value.
- R5: With `cfg_chain`=1 and `cfg_encrypt`=0 (CBC decrypt), the word is sent unchanged. The output is the result XOR the chain value, and the word that was sent becomes the new chain value.
- R6: At each accepted start, the chain value is loaded with the IV {`iv_w3`,`iv_w2`,`iv_w1`,`iv_w0`}, with `iv_w3` in bits 127:96 and `iv_w0` in bits 31:0.
- R7: At most one request is outstanding at the cipher. No new request is raised, and no new input word is accepted, until the previous result has been taken.
- R8: On the request and output streams, once TVALID is raised it stays high, with TDATA stable, until TREADY is seen.
- R9: `grp_done` is high for one cycle. That cycle follows the handshake of the group's last output word, or, for a group of length 0, the cycle in which the start was accepted. No stream activity takes place for a group of length 0.
- R10: A `grp_start` given in the same cycle that `grp_done` is high is accepted, and the new group runs with its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_start | input | 1 | Start-of-group pulse |
| cfg_chain | input | 1 | 0 = ECB, 1 = CBC |
| cfg_encrypt | input | 1 | 0 = decrypt, 1 = encrypt |
| iv_w3 | input | 32 | IV bits 127:96 |
| iv_w2 | input | 32 | IV bits 95:64 |
| iv_w1 | input | 32 | IV bits 63:32 |
| iv_w0 | input | 32 | IV bits 31:0 |
| grp_len | input | LEN_W (16) | Words in the group |
| in_tdata | input | 128 | Input word |
| in_tvalid | input | 1 | Input word valid |
| in_tready | output | 1 | Input word accepted |
| cph_req_tdata | output | 128 | Cipher input |
| cph_req_tvalid | output | 1 | Cipher input valid |
| cph_req_tready | input | 1 | Cipher takes input |
| cph_res_tdata | input | 128 | Cipher result |
| cph_res_tvalid | input | 1 | Cipher result valid |
| cph_res_tready | output | 1 | Result taken |
| out_tdata | output | 128 | Chained output word |
| out_tvalid | output | 1 | Output valid |
| out_tready | input | 1 | Output accepted |
| grp_done | output | 1 | Group finished pulse |

## Verification
Two things can land in the same cycle: a group finishing, with `grp_done` high, and a new start request. The bench raises `grp_start` in exactly the cycle in which it sees `grp_done`. It then judges that the following group runs with its own mode and IV, and produces the words the bench's own model predicts. The other overlap is a start pulse arriving in the middle of a running group. The bench pulses `grp_start` with a different configuration while a cipher request is stalled. It then confirms that every remaining word, and the single `grp_done`, still match the original group.

// File: rtl/chain_pkg.sv
package chain_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_ISSUE,
        PH_WAIT,
        PH_EMIT
    } phase_e;

endpackage

// File: rtl/chain_mixer.sv
module chain_mixer #(
    parameter int DATA_W = 128
) (
    input  logic              use_chain,
    input  logic              encrypt,
    input  logic [DATA_W-1:0] chain,
    input  logic [DATA_W-1:0] word_in,
    input  logic [DATA_W-1:0] sent,
    input  logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] cipher_in,
    output logic [DATA_W-1:0] word_out,
    output logic [DATA_W-1:0] chain_next
);

    always_comb begin
        cipher_in  = word_in;
        word_out   = result;
        chain_next = chain;
        if (use_chain) begin
            if (encrypt) begin
                cipher_in  = word_in ^ chain;
                chain_next = result;
            end else begin
                word_out   = result ^ chain;
                chain_next = sent;
            end
        end
    end

endmodule

// File: rtl/chain_seq.sv
module chain_seq
    import chain_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_chain,
    input  logic              cfg_encrypt,
    input  logic [DATA_W-1:0] iv,
    input  logic [LEN_W-1:0]  len,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] req_data,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              res_valid,
    output logic              res_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done,
    output logic              mix_chain,
    output logic              mix_encrypt,
    output logic [DATA_W-1:0] chain_val,
    output logic [DATA_W-1:0] sent_val,
    input  logic [DATA_W-1:0] mix_cipher_in,
    input  logic [DATA_W-1:0] mix_word_out,
    input  logic [DATA_W-1:0] mix_chain_next
);

    typedef struct packed {
        phase_e             phase;
        logic               use_chain;
        logic               encrypt;
        logic [LEN_W-1:0]   remain;
        logic [DATA_W-1:0]  chain;
        logic [DATA_W-1:0]  sent;
        logic [DATA_W-1:0]  outw;
        logic               done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        in_ready  = 1'b0;
        req_valid = 1'b0;
        res_ready = 1'b0;
        out_valid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.use_chain = cfg_chain;
                    st_d.encrypt   = cfg_encrypt;
                    st_d.chain     = iv;
                    st_d.remain    = len;
                    if (len == '0) st_d.done  = 1'b1;
                    else           st_d.phase = PH_FETCH;
                end
            end
            PH_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    st_d.sent  = mix_cipher_in;
                    st_d.phase = PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                req_valid = 1'b1;
                if (req_ready) st_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                res_ready = 1'b1;
                if (res_valid) begin
                    st_d.outw   = mix_word_out;
                    st_d.chain  = mix_chain_next;
                    st_d.remain = st_q.remain - 1'b1;
                    st_d.phase  = PH_EMIT;
                end
            end
            PH_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    if (st_q.remain == '0) begin
                        st_d.done  = 1'b1;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.phase = PH_FETCH;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_data    = st_q.sent;
    assign out_data    = st_q.outw;
    assign done        = st_q.done;
    assign mix_chain   = st_q.use_chain;
    assign mix_encrypt = st_q.encrypt;
    assign chain_val   = st_q.chain;
    assign sent_val    = st_q.sent;

endmodule

// File: rtl/cbc_chain_engine.sv
module cbc_chain_engine #(
    parameter int DATA_W = 128,
    parameter int CFG_W  = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_start,
    input  logic              cfg_chain,
    input  logic              cfg_encrypt,
    input  logic [CFG_W-1:0]  iv_w3,
    input  logic [CFG_W-1:0]  iv_w2,
    input  logic [CFG_W-1:0]  iv_w1,
    input  logic [CFG_W-1:0]  iv_w0,
    input  logic [LEN_W-1:0]  grp_len,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic              in_tvalid,
    output logic              in_tready,
    output logic [DATA_W-1:0] cph_req_tdata,
    output logic              cph_req_tvalid,
    input  logic              cph_req_tready,
    input  logic [DATA_W-1:0] cph_res_tdata,
    input  logic              cph_res_tvalid,
    output logic              cph_res_tready,
    output logic [DATA_W-1:0] out_tdata,
    output logic              out_tvalid,
    input  logic              out_tready,
    output logic              grp_done
);

    localparam int IV_PARTS = DATA_W / CFG_W;

    logic [IV_PARTS-1:0][CFG_W-1:0] iv_parts;
    logic [DATA_W-1:0] iv_vec;
    logic              m_chain, m_enc;
    logic [DATA_W-1:0] chain_v, sent_v, c_in, w_out, c_next;

    assign iv_parts = {iv_w3, iv_w2, iv_w1, iv_w0};
    assign iv_vec   = iv_parts;

    chain_mixer #(.DATA_W(DATA_W)) u_mix (
        .use_chain  (m_chain),
        .encrypt    (m_enc),
        .chain      (chain_v),
        .word_in    (in_tdata),
        .sent       (sent_v),
        .result     (cph_res_tdata),
        .cipher_in  (c_in),
        .word_out   (w_out),
        .chain_next (c_next)
    );

    chain_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (grp_start),
        .cfg_chain      (cfg_chain),
        .cfg_encrypt    (cfg_encrypt),
        .iv             (iv_vec),
        .len            (grp_len),
        .in_valid       (in_tvalid),
        .in_ready       (in_tready),
        .req_data       (cph_req_tdata),
        .req_valid      (cph_req_tvalid),
        .req_ready      (cph_req_tready),
        .res_valid      (cph_res_tvalid),
        .res_ready      (cph_res_tready),
        .out_data       (out_tdata),
        .out_valid      (out_tvalid),
        .out_ready      (out_tready),
        .done           (grp_done),
        .mix_chain      (m_chain),
        .mix_encrypt    (m_enc),
        .chain_val      (chain_v),
        .sent_val       (sent_v),
        .mix_cipher_in  (c_in),
        .mix_word_out   (w_out),
        .mix_chain_next (c_next)
    );

endmodule

// File: rtl/chain_engine_checks.sv
module chain_engine_checks #(
    parameter int DATA_W = 128,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grp_start,
    input logic [LEN_W-1:0]  grp_len,
    input logic              in_tready,
    input logic [DATA_W-1:0] cph_req_tdata,
    input logic              cph_req_tvalid,
    input logic              cph_req_tready,
    input logic              cph_res_tvalid,
    input logic              cph_res_tready,
    input logic [DATA_W-1:0] out_tdata,
    input logic              out_tvalid,
    input logic              out_tready,
    input logic              grp_done
);

    logic [1:0] pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= pending + {1'b0, cph_req_tvalid & cph_req_tready}
                               - {1'b0, cph_res_tvalid & cph_res_tready};
        end
    end

    assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req_tvalid |-> pending == 2'd0);

    assert_no_fetch_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_tready |-> pending == 2'd0);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req_tvalid && !cph_req_tready |=> cph_req_tvalid && $stable(cph_req_tdata));

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata));

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_done) |-> $past((out_tvalid && out_tready) || (grp_start && grp_len == '0)));

endmodule

bind cbc_chain_engine chain_engine_checks #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .grp_start      (grp_start),
    .grp_len        (grp_len),
    .in_tready      (in_tready),
    .cph_req_tdata  (cph_req_tdata),
    .cph_req_tvalid (cph_req_tvalid),
    .cph_req_tready (cph_req_tready),
    .cph_res_tvalid (cph_res_tvalid),
    .cph_res_tready (cph_res_tready),
    .out_tdata      (out_tdata),
    .out_tvalid     (out_tvalid),
    .out_tready     (out_tready),
    .grp_done       (grp_done)
);

// File: tb/sim_cbc_chain_engine.sv
module sim_cbc_chain_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         grp_start = 1'b0;
    logic         cfg_chain = 1'b0;
    logic         cfg_encrypt = 1'b0;
    logic [31:0]  iv_w3 = '0, iv_w2 = '0, iv_w1 = '0, iv_w0 = '0;
    logic [15:0]  grp_len = '0;
    logic [127:0] in_tdata = '0;
    logic         in_tvalid = 1'b0;
    logic         in_tready;
    logic [127:0] cph_req_tdata;
    logic         cph_req_tvalid;
    logic         cph_req_tready = 1'b0;
    logic [127:0] cph_res_tdata = '0;
    logic         cph_res_tvalid = 1'b0;
    logic         cph_res_tready;
    logic [127:0] out_tdata;
    logic         out_tvalid;
    logic         out_tready = 1'b0;
    logic         grp_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit busy_poke = 0;

    always #5 clk = ~clk;

    cbc_chain_engine u0 (.*);

    function automatic logic [127:0] cipher_f(input logic [127:0] x);
        return {x[63:0], x[127:64]} ^ 128'h5a3c_96e1_0f1e_2d3c_4b5a_6978_8796_a5b4;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic start_group(input bit cbc, input bit enc, input logic [127:0] iv, input int len);
        cfg_chain = cbc; cfg_encrypt = enc; grp_len = 16'(len);
        {iv_w3, iv_w2, iv_w1, iv_w0} = iv;
        grp_start = 1'b1;
    endtask

    // runs one group whose start is being driven in the current cycle
    task automatic run_group(input bit cbc, input bit enc, input logic [127:0] iv, input int len,
                             input bit chain_next, input bit nc, input bit ne,
                             input logic [127:0] niv, input int nlen);
        logic [127:0] chain = iv;
        for (int i = 0; i < len; i++) begin
            logic [127:0] w = rnd128();
            logic [127:0] exp_in = (cbc && enc) ? (w ^ chain) : w;
            logic [127:0] res = cipher_f(exp_in);
            logic [127:0] exp_out = (cbc && !enc) ? (res ^ chain) : res;
            logic [127:0] held;
            string tag = !cbc ? "R3" : (i == 0 ? "R6" : (enc ? "R4" : "R5"));
            int stall;
            @(negedge clk);
            grp_start = 1'b0;
            if (i == 0) begin
                cfg_chain = ~cbc; cfg_encrypt = ~enc;
                {iv_w3, iv_w2, iv_w1, iv_w0} = rnd128(); grp_len = 16'd9;
            end
            in_tdata = w; in_tvalid = 1'b1;
            while (!in_tready) @(negedge clk);
            @(negedge clk);
            in_tvalid = 1'b0;
            while (!cph_req_tvalid) @(negedge clk);
            chk(cph_req_tdata == exp_in, {tag, " cipher input"}, cph_req_tdata, exp_in);
            held = cph_req_tdata;
            stall = int'($urandom % 3);
            if (busy_poke && i == 0) stall = 2;
            for (int s = 0; s < stall; s++) begin
                chk(in_tready == 1'b0, "R7 no fetch while pending", 128'(in_tready), 0);
                if (busy_poke && i == 0 && s == 0) start_group(~cbc, ~enc, rnd128(), 0);
                @(negedge clk);
                grp_start = 1'b0;
                chk(cph_req_tvalid && cph_req_tdata == held, "R8 request hold", cph_req_tdata, held);
            end
            cph_req_tready = 1'b1;
            @(negedge clk);
            cph_req_tready = 1'b0;
            chk(cph_req_tvalid == 1'b0, "R7 single request", 128'(cph_req_tvalid), 0);
            cph_res_tdata = res; cph_res_tvalid = 1'b1;
            while (!cph_res_tready) @(negedge clk);
            @(negedge clk);
            cph_res_tvalid = 1'b0;
            while (!out_tvalid) @(negedge clk);
            chk(out_tdata == exp_out, {tag, " output word"}, out_tdata, exp_out);
            stall = int'($urandom % 3);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(out_tvalid && out_tdata == exp_out, "R8 output hold", out_tdata, exp_out);
            end
            out_tready = 1'b1;
            @(negedge clk);
            out_tready = 1'b0;
            chk(grp_done == (i == len - 1), "R9 done timing", 128'(grp_done), 128'(i == len - 1));
            if (cbc) chain = enc ? res : exp_in;
        end
        if (len == 0) begin
            @(negedge clk);
            grp_start = 1'b0;
            chk(grp_done == 1'b1, "R9 empty group done", 128'(grp_done), 1);
            chk(!in_tready && !cph_req_tvalid && !out_tvalid, "R9 empty group no traffic", 0, 0);
        end
        if (chain_next) begin
            start_group(nc, ne, niv, nlen);
        end else begin
            @(negedge clk);
            chk(grp_done == 1'b0, "R9 done single cycle", 128'(grp_done), 0);
            chk(!in_tready && !cph_req_tvalid && !out_tvalid, "R2 idle after group", 0, 0);
        end
    endtask

    task automatic group(input bit cbc, input bit enc, input logic [127:0] iv, input int len);
        @(negedge clk);
        start_group(cbc, enc, iv, len);
        run_group(cbc, enc, iv, len, 1'b0, 1'b0, 1'b0, '0, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) begin
            @(negedge clk);
            chk(!in_tready && !cph_req_tvalid && !cph_res_tready && !out_tvalid && !grp_done,
                "R1 reset outputs", 0, 0);
        end
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(!in_tready && !cph_req_tvalid && !cph_res_tready && !out_tvalid && !grp_done,
                "R1 idle outputs", 0, 0);
        end
        group(1'b0, 1'b1, rnd128(), 4);
        group(1'b0, 1'b0, rnd128(), 3);
        group(1'b1, 1'b1, 128'h0000_0003_0000_0002_0000_0001_0000_0000, 5);
        group(1'b1, 1'b0, rnd128(), 5);
        group(1'b1, 1'b1, rnd128(), 1);
        group(1'b1, 1'b0, rnd128(), 0);
        begin
            logic [127:0] iv_a = rnd128();
            logic [127:0] iv_b = rnd128();
            @(negedge clk);
            start_group(1'b1, 1'b1, iv_a, 3);
            run_group(1'b1, 1'b1, iv_a, 3, 1'b1, 1'b1, 1'b0, iv_b, 4);
            run_group(1'b1, 1'b0, iv_b, 4, 1'b0, 1'b0, 1'b0, '0, 0); // R10
        end
        busy_poke = 1'b1;
        group(1'b1, 1'b1, rnd128(), 3); // R2 start ignored while busy
        busy_poke = 1'b0;
        for (int g = 0; g < 8; g++) begin
            group(1'($urandom), 1'($urandom), rnd128(), int'($urandom % 6) + 1);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule